// File: doc/BRIEF.md
# UART Register File and Interrupt Controller

This block is the register side of a simple byte-at-a-time UART, attached to an APB slave port. It holds one transmit byte and one receive byte, a set of status flags, a control register of enables, a 20-bit baud divisor and twelve read-only identification bytes. It drives five interrupt lines: one each for transmit, receive, transmit overrun and receive overrun, and one combined line.

On the line side it hands the held transmit byte to an 8N1 serializer through a request/accept handshake. It takes received bytes from a deserializer as a one-cycle strobe with data. The divisor and a validity flag go out to both. Software polls or takes interrupts, writes bytes to the data register and reads received bytes back from it. Overruns are kept as sticky flags until software clears them.

Top module: `uart_apb_regs`

## Requirements
- R1: After reset every register reads zero, `tx_req` is low and all five interrupt outputs are low.
- R2: Word 0x08 (control) stores bits [6:0] of the write and reads back with the upper bits zero. Word 0x10 (divisor) stores bits [19:0]. Control bits are: 0 transmit enable, 1 receive enable, 2 transmit interrupt enable, 3 receive interrupt enable, 4 transmit-overrun interrupt enable, 5 receive-overrun interrupt enable, 6 test (stored only).
- R3: Words 0xFD0 to 0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x21, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, and ignore writes. Other unmapped words read zero and ignore writes. `pready` is always 1 and `pslverr` is always 0.
- R4: A write to word 0x00 (data) while the transmit buffer is empty stores the byte and sets status bit 0 (transmit full). `tx_req` is high with `tx_data` equal to the byte while status bit 0, control bit 0 and a valid divisor are all present.
- R5: A write to the data word while status bit 0 is set, and not accepted in that same cycle, sets status bit 2 (transmit overrun) and replaces the held byte.
- R6: `tx_ack` while `tx_req` is high clears status bit 0. If control bit 2 is set, it also sets interrupt-status bit 0 (word 0x0C).
- R7: A `rx_strobe` while control bit 1 is set stores `rx_data` and sets status bit 1 (receive full). With control bit 1 clear, the strobe is discarded and status and buffer keep their values.
- R8: A stored byte arriving while status bit 1 is set, and not read in the same cycle, sets status bit 3 (receive overrun), overwrites the buffer and leaves bit 1 set.
- R9: Reading the data word returns the receive buffer and clears status bit 1.
- R10: When a byte is stored with control bit 3 set, interrupt-status bit 1 is set and stays set until cleared.
- R11: Interrupt-status bits 2 and 3 always equal status bits 2 and 3 ANDed with control bits 4 and 5, following any change of either.
- R12: Writing 1 to status bits 2 or 3 clears them, and status bits 0 and 1 ignore writes. Writing 1 to any interrupt-status bit clears it, and bits 2 and 3 also clear the matching status overrun flag. A new event in the same cycle wins over a clear.
- R13: `irq_tx`, `irq_rx`, `irq_txovr` and `irq_rxovr` follow interrupt-status bits 0 to 3, and `irq_any` is their OR.
- R14: A divisor below 16 drives `baud_ok` low and holds `tx_req` low. A divisor of 16 or more drives `baud_ok` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | APB clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address within the 4 KB window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never an error |
| tx_data | output | 8 | Held transmit byte |
| tx_req | output | 1 | Transmit byte available to serializer |
| tx_ack | input | 1 | Serializer accepts the byte |
| rx_data | input | 8 | Received byte |
| rx_strobe | input | 1 | Received byte valid, one cycle |
| baud_div | output | 20 | Divisor for the serial bit clock |
| baud_ok | output | 1 | Divisor is at least 16 |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_txovr | output | 1 | Transmit overrun interrupt |
| irq_rxovr | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of all interrupts |

## Verification
Read data is combinational in the APB access phase, so the bench samples `prdata` in that phase. Any register change takes effect at the access edge. `tx_req`, `tx_data`, `baud_ok` and the interrupt lines update one clock after the access, strobe or accept edge that caused them. The bench's bus and line tasks each return at the falling edge after their active edge, and every check is made there or in a following read. Sweeps cover all 128 control values against set overrun flags, a range of divisors around 16 including truncation of wide writes, all twelve identification words and all 256 receive byte values.

// File: rtl/uart_regs_pkg.sv
`timescale 1ns/1ps
package uart_regs_pkg;
  localparam int DATA_W  = 8;
  localparam int CTRL_W  = 7;
  localparam int WIDX_W  = 10;

  // word indices (byte address >> 2)
  localparam logic [WIDX_W-1:0] W_DATA     = 10'h000;
  localparam logic [WIDX_W-1:0] W_STATE    = 10'h001;
  localparam logic [WIDX_W-1:0] W_CTRL     = 10'h002;
  localparam logic [WIDX_W-1:0] W_INT      = 10'h003;
  localparam logic [WIDX_W-1:0] W_DIV      = 10'h004;
  localparam logic [WIDX_W-1:0] W_ID_FIRST = 10'h3F4;

  // control bit positions
  localparam int C_TXEN   = 0;
  localparam int C_RXEN   = 1;
  localparam int C_TXIE   = 2;
  localparam int C_RXIE   = 3;
  localparam int C_TXOIE  = 4;
  localparam int C_RXOIE  = 5;

  // status / interrupt-status bit positions
  localparam int S_TX     = 0;
  localparam int S_RX     = 1;
  localparam int S_TXOVR  = 2;
  localparam int S_RXOVR  = 3;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'h04;
      4'd4:    b = 8'h21;
      4'd5:    b = 8'hB8;
      4'd6:    b = 8'h1B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/uart_tx_hold.sv
`timescale 1ns/1ps
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              line_en,
  input  logic              rate_ok,
  input  logic              ack,
  input  logic              clr_ovr,
  output logic              full,
  output logic              ovr,
  output logic              req,
  output logic [DATA_W-1:0] hold_byte,
  output logic              accepted
);
  logic full_d, ovr_d;

  assign req      = full & line_en & rate_ok;
  assign accepted = req & ack;

  always_comb begin
    full_d = full;
    if (accepted) full_d = 1'b0;
    if (wr_en)    full_d = 1'b1;
    ovr_d = (ovr & ~clr_ovr) | (wr_en & full & ~accepted);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      full <= full_d;
      ovr  <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_byte <= '0;
    else if (wr_en) hold_byte <= wr_byte;
  end

  a_r5_overrun_on_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !ack) |=> ovr);
  a_r6_accept_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && !wr_en) |=> !full);
endmodule

// File: rtl/uart_rx_hold.sv
`timescale 1ns/1ps
module uart_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              line_en,
  input  logic              rd_en,
  input  logic              clr_ovr,
  output logic              full,
  output logic              ovr,
  output logic [DATA_W-1:0] hold_byte,
  output logic              stored
);
  logic full_d, ovr_d;

  assign stored = strobe & line_en;

  always_comb begin
    full_d = full;
    if (rd_en)  full_d = 1'b0;
    if (stored) full_d = 1'b1;
    ovr_d = (ovr & ~clr_ovr) | (stored & full & ~rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      full <= full_d;
      ovr  <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_byte <= '0;
    else if (stored) hold_byte <= in_byte;
  end

  a_r7_drop_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !line_en) |=> $stable(hold_byte));
  a_r8_overrun_on_full_store: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && line_en && full && !rd_en) |=> (ovr && full));
  a_r9_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !strobe) |=> !full);
endmodule

// File: rtl/uart_apb_regs.sv
`timescale 1ns/1ps
module uart_apb_regs
  import uart_regs_pkg::*;
#(
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [11:0]       paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_req,
  input  logic              tx_ack,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_strobe,
  output logic [DIV_W-1:0]  baud_div,
  output logic              baud_ok,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_txovr,
  output logic              irq_rxovr,
  output logic              irq_any
);
  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);

  logic [WIDX_W-1:0] widx;
  logic              wr_acc, rd_acc;
  logic              wr_data, wr_state, wr_ctrl, wr_int, wr_div, rd_data;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic              tx_is_q, tx_is_d, rx_is_q, rx_is_d;
  logic              tx_full, tx_ovr, tx_done, tx_clr;
  logic              rx_full, rx_ovr, rx_done, rx_clr;
  logic [DATA_W-1:0] rx_byte;
  logic [3:0]        id_idx;
  logic              unused_bits;

  assign unused_bits = ^{paddr[1:0], pwdata[31:DIV_W]};

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assign widx   = paddr[11:2];
  assign wr_acc = psel & penable & pwrite;
  assign rd_acc = psel & penable & ~pwrite;

  assign wr_data  = wr_acc && (widx == W_DATA);
  assign wr_state = wr_acc && (widx == W_STATE);
  assign wr_ctrl  = wr_acc && (widx == W_CTRL);
  assign wr_int   = wr_acc && (widx == W_INT);
  assign wr_div   = wr_acc && (widx == W_DIV);
  assign rd_data  = rd_acc && (widx == W_DATA);

  assign tx_clr = (wr_state | wr_int) & pwdata[S_TXOVR];
  assign rx_clr = (wr_state | wr_int) & pwdata[S_RXOVR];

  assign baud_div = div_q;
  assign baud_ok  = (div_q >= DIV_FLOOR);

  uart_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_data),
    .wr_byte   (pwdata[DATA_W-1:0]),
    .line_en   (ctrl_q[C_TXEN]),
    .rate_ok   (baud_ok),
    .ack       (tx_ack),
    .clr_ovr   (tx_clr),
    .full      (tx_full),
    .ovr       (tx_ovr),
    .req       (tx_req),
    .hold_byte (tx_data),
    .accepted  (tx_done)
  );

  uart_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (rx_strobe),
    .in_byte   (rx_data),
    .line_en   (ctrl_q[C_RXEN]),
    .rd_en     (rd_data),
    .clr_ovr   (rx_clr),
    .full      (rx_full),
    .ovr       (rx_ovr),
    .hold_byte (rx_byte),
    .stored    (rx_done)
  );

  // sticky interrupt-status bits: a new event wins over a same-cycle clear
  always_comb begin
    tx_is_d = (tx_is_q & ~(wr_int & pwdata[S_TX])) | (tx_done & ctrl_q[C_TXIE]);
    rx_is_d = (rx_is_q & ~(wr_int & pwdata[S_RX])) | (rx_done & ctrl_q[C_RXIE]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_is_q <= 1'b0;
      rx_is_q <= 1'b0;
    end else begin
      tx_is_q <= tx_is_d;
      rx_is_q <= rx_is_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= pwdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (wr_div) div_q <= pwdata[DIV_W-1:0];
  end

  assign irq_tx    = tx_is_q;
  assign irq_rx    = rx_is_q;
  assign irq_txovr = tx_ovr & ctrl_q[C_TXOIE];
  assign irq_rxovr = rx_ovr & ctrl_q[C_RXOIE];
  assign irq_any   = irq_tx | irq_rx | irq_txovr | irq_rxovr;

  assign id_idx = 4'(widx - W_ID_FIRST);

  always_comb begin
    prdata = '0;
    if (widx >= W_ID_FIRST) begin
      prdata[7:0] = id_byte(id_idx);
    end else begin
      case (widx)
        W_DATA:  prdata[DATA_W-1:0] = rx_byte;
        W_STATE: prdata[3:0] = {rx_ovr, tx_ovr, rx_full, tx_full};
        W_CTRL:  prdata[CTRL_W-1:0] = ctrl_q;
        W_INT:   prdata[3:0] = {irq_rxovr, irq_txovr, rx_is_q, tx_is_q};
        W_DIV:   prdata[DIV_W-1:0] = div_q;
        default: prdata = '0;
      endcase
    end
  end

  a_r2_ctrl_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q == $past(pwdata[CTRL_W-1:0])));
  a_r11_txovr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_txovr) |-> ctrl_q[C_TXOIE]);
  a_r12_int_clear_rxovr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_int && pwdata[S_RXOVR] && !rx_strobe) |=> (!irq_rxovr && !rx_ovr));
  a_r14_no_req_bad_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q < DIV_FLOOR) |-> !tx_req);
endmodule

// File: tb/uart_apb_regs_tb.sv
`timescale 1ns/1ps
module uart_apb_regs_tb;
  logic        clk, rst_n;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic        pready, pslverr;
  logic [7:0]  tx_data, rx_data;
  logic        tx_req, tx_ack, rx_strobe;
  logic [19:0] baud_div;
  logic        baud_ok;
  logic        irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  uart_apb_regs u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .tx_data(tx_data), .tx_req(tx_req), .tx_ack(tx_ack),
    .rx_data(rx_data), .rx_strobe(rx_strobe),
    .baud_div(baud_div), .baud_ok(baud_ok),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txovr(irq_txovr), .irq_rxovr(irq_rxovr),
    .irq_any(irq_any)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    apb_rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic rx_byte(input logic [7:0] b);
    @(negedge clk);
    rx_data = b; rx_strobe = 1'b1;
    @(negedge clk);
    rx_strobe = 1'b0;
  endtask

  task automatic tx_accept();
    @(negedge clk);
    tx_ack = 1'b1;
    @(negedge clk);
    tx_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] ids [12];
    ids = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h21, 8'hB8, 8'h1B, 8'h00,
            8'h0D, 8'hF0, 8'h05, 8'hB1};
    rst_n = 1'b0; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    tx_ack = 0; rx_strobe = 0; rx_data = 0;
    repeat (3) @(negedge clk);
    check("R1 tx_req in reset", {31'b0, tx_req}, 0);
    check("R1 irq_any in reset", {31'b0, irq_any}, 0);
    rst_n = 1'b1;

    // R1: every register zero
    for (int w = 0; w < 5; w++) rd_chk("R1 reset reg", 12'(w * 4), 0);
    check("R1 irq lines", {27'b0, irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any}, 0);
    check("R3 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);

    // R3: identification words, write ignored, unmapped
    for (int i = 0; i < 12; i++) rd_chk("R3 id byte", 12'(12'hFD0 + i * 4), {24'b0, ids[i]});
    apb_wr(12'hFD0, 32'hFF);
    rd_chk("R3 id write ignored", 12'hFD0, 32'h04);
    apb_wr(12'h014, 32'hFFFF_FFFF);
    rd_chk("R3 unmapped 0x014", 12'h014, 0);
    rd_chk("R3 unmapped 0x800", 12'h800, 0);
    rd_chk("R3 unmapped 0xFCC", 12'hFCC, 0);

    // R4/R5 with transmit disabled
    apb_wr(12'h000, 32'h11);
    rd_chk("R4 tx full set", 12'h004, 32'h1);
    check("R4 no req while disabled", {31'b0, tx_req}, 0);
    apb_wr(12'h000, 32'h22);
    rd_chk("R5 tx overrun", 12'h004, 32'h5);
    check("R5 byte replaced", {24'b0, tx_data}, 32'h22);

    // R7/R8/R9 receive path, interrupt enable off
    apb_wr(12'h008, 32'h2);
    rx_byte(8'h33);
    rd_chk("R7 rx full", 12'h004, 32'h7);
    rx_byte(8'h44);
    rd_chk("R8 rx overrun", 12'h004, 32'hF);
    rd_chk("R8 overwritten data", 12'h000, 32'h44);
    rd_chk("R9 read clears rx full", 12'h004, 32'hD);
    rd_chk("R10 no rx irq without enable", 12'h00C, 0);

    // R2/R11/R13: sweep all control values with both overruns set
    for (int v = 0; v < 128; v++) begin
      logic [31:0] e;
      apb_wr(12'h008, 32'hFFFF_FF80 | 32'(v));
      rd_chk("R2 ctrl readback", 12'h008, 32'(v));
      e = (32'((v >> 4) & 1) << 2) | (32'((v >> 5) & 1) << 3);
      rd_chk("R11 overrun irq status", 12'h00C, e);
      check("R13 irq lines",
            {27'b0, irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any},
            {27'b0, 1'b0, 1'b0, e[2], e[3], |e});
    end
    apb_wr(12'h008, 0);

    // R12: write-one-to-clear behaviour
    apb_wr(12'h004, 32'h3);
    rd_chk("R12 full bits read-only", 12'h004, 32'hD);
    apb_wr(12'h004, 32'h4);
    rd_chk("R12 state clears tx overrun", 12'h004, 32'h9);
    apb_wr(12'h008, 32'h30);
    rd_chk("R11 rx overrun irq", 12'h00C, 32'h8);
    check("R13 irq_rxovr", {31'b0, irq_rxovr}, 1);
    apb_wr(12'h00C, 32'h8);
    rd_chk("R12 int clear reaches state", 12'h004, 32'h1);
    rd_chk("R12 int status cleared", 12'h00C, 0);
    check("R13 irq_any low", {31'b0, irq_any}, 0);

    // R14/R2: divisor sweep with a byte held and transmit enabled
    apb_wr(12'h008, 32'h1);
    for (int v = 0; v < 24; v++) begin
      apb_wr(12'h010, 32'(v));
      rd_chk("R2 div readback", 12'h010, 32'(v));
      check("R14 baud_ok", {31'b0, baud_ok}, {31'b0, v >= 16});
      check("R14 tx_req gate", {31'b0, tx_req}, {31'b0, v >= 16});
    end
    apb_wr(12'h010, 32'h1234_5678);
    rd_chk("R2 div truncated", 12'h010, 32'h4_5678);
    check("R2 baud_div port", {12'b0, baud_div}, 32'h4_5678);
    apb_wr(12'h010, 32'h0010_000F);
    check("R14 truncated low divisor", {31'b0, tx_req}, 0);
    apb_wr(12'h010, 32'd16);
    check("R4 tx_data on req", {23'b0, tx_req, tx_data}, 32'h122);

    // R6: accept with interrupt enable
    apb_wr(12'h008, 32'h5);
    tx_accept();
    check("R6 req drops", {31'b0, tx_req}, 0);
    check("R13 irq_tx", {30'b0, irq_tx, irq_any}, 32'h3);
    rd_chk("R6 tx empty", 12'h004, 0);
    rd_chk("R6 tx irq status", 12'h00C, 32'h1);
    apb_wr(12'h00C, 32'h1);
    rd_chk("R12 tx irq cleared", 12'h00C, 0);

    // R4/R6: fresh byte, accept without interrupt enable
    apb_wr(12'h008, 32'h1);
    apb_wr(12'h000, 32'h5A);
    check("R4 new byte requested", {23'b0, tx_req, tx_data}, 32'h15A);
    rd_chk("R4 state", 12'h004, 32'h1);
    tx_accept();
    rd_chk("R6 no irq without enable", 12'h00C, 0);

    // R7: discard while receive disabled
    apb_wr(12'h008, 0);
    rx_byte(8'h77);
    rd_chk("R7 state unchanged", 12'h004, 0);
    rd_chk("R7 buffer kept", 12'h000, 32'h44);

    // R10: receive interrupt
    apb_wr(12'h008, 32'hA);
    rx_byte(8'h99);
    check("R10 irq_rx", {31'b0, irq_rx}, 1);
    rd_chk("R10 rx irq status", 12'h00C, 32'h2);
    rd_chk("R9 data", 12'h000, 32'h99);
    rd_chk("R9 rx empty", 12'h004, 0);
    rd_chk("R10 status sticky", 12'h00C, 32'h2);
    apb_wr(12'h00C, 32'h2);
    rd_chk("R12 rx irq cleared", 12'h00C, 0);

    // R9: every byte value through the receive buffer
    apb_wr(12'h008, 32'h2);
    for (int b = 0; b < 256; b++) begin
      rx_byte(8'(b));
      rd_chk("R9 byte sweep", 12'h000, 32'(b));
      if ((b % 32) == 0) rd_chk("R9 sweep state", 12'h004, 0);
    end

    finish_run();
  end
endmodule